// File: doc/BRIEF.md
# Serial Controller Host Register Bank

This block is the processor-facing side of an asynchronous serial controller. A host reaches it through a 3-bit offset, separate read and write strobes and byte-wide data buses. Behind that port sit the interrupt enable, line control, modem control, scratch and 16-bit baud divisor registers. The block also presents the line status and modem status views, and a write-only FIFO control port. The serializer, baud generator and FIFO storage live elsewhere. They feed status levels into this block and take its strobes: pop, push, FIFO clear, divisor and line configuration.

Offsets 0 and 1 are banked. While the top bit of line control is clear, they reach the data path and interrupt enable. While it is set, they reach the divisor bytes. The block merges four interrupt causes into one request line. Each cause is dropped by one particular host access. Master reset puts the control and status registers into fixed values. It leaves the scratch byte, the divisor and the last transmitted byte untouched.

Top module: `uart_host_regs`

## Requirements
- R1: With line control bit 7 clear, offset 0 reads the receive data input and a write to it sends a byte, and offset 1 is interrupt enable with bits 7:4 reading zero. With bit 7 set, offset 0 is the divisor low byte and offset 1 the divisor high byte. Offsets 3, 4 and 7 (line control, modem control, scratch) read back what was written, whatever bit 7 holds.
- R2: After master reset, interrupt enable, line control and modem control read 0x00, identification (offset 2) reads 0x01, line status (offset 5) reads 0x60 while the transmit inputs are high, modem status (offset 6) bits 3:0 read zero, and rts_n and dtr_n are high.
- R3: Master reset leaves the scratch byte, both divisor bytes and tx_data_o unchanged.
- R4: Modem control bits 7:6 read zero. dtr_n is the inverse of bit 0 and rts_n the inverse of bit 1, one cycle after the write.
- R5: Modem status bits 7:4 are the inverted live levels of modem_n_i[3:0]. Bits 3:0 set one cycle after the matching input changes and all clear after a modem status read, unless the input changes again.
- R6: Line status bit 0 is rx_ready_i. Bits 4:1 hold rx_err_i[3:0] sticky until a line status read. Bit 5 is tx_hold_empty_i and bit 6 is tx_idle_i, each registered one cycle. Bit 7 reads zero.
- R7: Identification bits 3:1 report the highest pending enabled cause: 011 line error, 010 data ready, 001 holding empty, 000 modem change. Bit 0 is 0 when any cause is pending, and bits 7:6 both equal the stored FIFO enable bit.
- R8: irq is high exactly while identification bit 0 is low. Enable bit 0 gates data ready, bit 1 holding empty, bit 2 line error and bit 3 modem change.
- R9: The data-ready cause is raised while rx_ready_i is high and is dropped only by a receive data read.
- R10: The holding-empty cause is raised when tx_hold_empty_i rises, or when enable bit 1 is written from 0 to 1 while the holding register is empty. It is dropped by a send-byte write, or by an identification read that reports it.
- R11: A write to offset 2 pulses rx_fifo_clr_o for one cycle when bit 1 is set, and tx_fifo_clr_o when bit 2 is set. Both pulse when bit 0 differs from the stored enable. The write changes no readable register other than identification bits 7:6.
- R12: A send-byte write pulses tx_push_o one cycle later, with tx_data_o holding the written byte. A receive data read pulses rx_pop_o one cycle later.
- R13: divisor_o is {high byte, low byte} and line_cfg_o is the line control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational on offset |
| irq | output | 1 | Interrupt request |
| rx_data_i | input | 8 | Byte at the head of the receive FIFO |
| rx_ready_i | input | 1 | Receive FIFO holds data |
| rx_err_i | input | 4 | Error events: overrun, parity, framing, break |
| tx_hold_empty_i | input | 1 | Transmit holding side empty |
| tx_idle_i | input | 1 | Transmitter fully idle |
| modem_n_i | input | 4 | Modem inputs, active low: CTS, DSR, RI, DCD |
| rts_n | output | 1 | Request to send, active low |
| dtr_n | output | 1 | Data terminal ready, active low |
| rx_pop_o | output | 1 | Receive FIFO pop pulse |
| tx_push_o | output | 1 | Transmit FIFO push pulse |
| tx_data_o | output | 8 | Byte to push |
| rx_fifo_clr_o | output | 1 | Receive FIFO clear pulse |
| tx_fifo_clr_o | output | 1 | Transmit FIFO clear pulse |
| divisor_o | output | 16 | Baud divisor |
| line_cfg_o | output | 8 | Line control value |

## Verification
The bench builds the block with its default widths: byte registers, four modem lines and four error bits. This is the only size, so every cause and offset is reachable. That brings the full priority ladder into reach. A line error stacked on pending data, and a holding-empty cause re-armed by an enable write and then by a status edge, can both be forced. The bench also issues a mid-run master reset after the scratch, divisor and transmit bytes hold known values. The surviving bytes can then be told apart from the reset ones.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
    localparam int DW       = 8;
    localparam int ERR_W    = 4;
    localparam int MDM_W    = 4;
    localparam int IER_W    = 4;
    localparam int MCR_W    = 6;
    localparam int DLAB_BIT = 7;
    localparam int DIV_W    = 2 * DW;

    localparam int IE_RDA  = 0;
    localparam int IE_THRE = 1;
    localparam int IE_RLS  = 2;
    localparam int IE_MS   = 3;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_IEN  = 3'd1;
    localparam logic [2:0] OFS_IDF  = 3'd2;
    localparam logic [2:0] OFS_LCR  = 3'd3;
    localparam logic [2:0] OFS_MCR  = 3'd4;
    localparam logic [2:0] OFS_LSR  = 3'd5;
    localparam logic [2:0] OFS_MSR  = 3'd6;

    typedef enum logic [2:0] {
        ID_MODEM = 3'b000,
        ID_THRE  = 3'b001,
        ID_RDA   = 3'b010,
        ID_RLS   = 3'b011
    } irq_id_e;

    typedef enum logic [3:0] {
        RS_RBR, RS_IER, RS_DLL, RS_DLM, RS_IIR,
        RS_LCR, RS_MCR, RS_LSR, RS_MSR, RS_SCR
    } rsel_e;

    typedef struct packed {
        logic rd_rbr;
        logic wr_thr;
        logic wr_ier;
        logic wr_dll;
        logic wr_dlm;
        logic rd_iir;
        logic wr_fcr;
        logic wr_lcr;
        logic wr_mcr;
        logic rd_lsr;
        logic rd_msr;
        logic wr_scr;
    } access_t;
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
    import uart_rb_pkg::*;
(
    input  logic    [2:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic          dlab,
    output access_t       acc,
    output rsel_e         rsel
);
    always_comb begin
        acc  = '0;
        rsel = RS_RBR;
        case (addr)
            OFS_DATA: begin
                rsel       = dlab ? RS_DLL : RS_RBR;
                acc.rd_rbr = rd_en & ~dlab;
                acc.wr_thr = wr_en & ~dlab;
                acc.wr_dll = wr_en & dlab;
            end
            OFS_IEN: begin
                rsel       = dlab ? RS_DLM : RS_IER;
                acc.wr_ier = wr_en & ~dlab;
                acc.wr_dlm = wr_en & dlab;
            end
            OFS_IDF: begin
                rsel       = RS_IIR;
                acc.rd_iir = rd_en;
                acc.wr_fcr = wr_en;
            end
            OFS_LCR: begin
                rsel       = RS_LCR;
                acc.wr_lcr = wr_en;
            end
            OFS_MCR: begin
                rsel       = RS_MCR;
                acc.wr_mcr = wr_en;
            end
            OFS_LSR: begin
                rsel       = RS_LSR;
                acc.rd_lsr = rd_en;
            end
            OFS_MSR: begin
                rsel       = RS_MSR;
                acc.rd_msr = rd_en;
            end
            default: begin
                rsel       = RS_SCR;
                acc.wr_scr = wr_en;
            end
        endcase
    end
endmodule

// File: rtl/uart_rb_modem.sv
module uart_rb_modem #(
    parameter int LINES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pins_n,
    input  logic             clr,
    output logic [LINES-1:0] level,
    output logic [LINES-1:0] delta
);
    typedef struct packed {
        logic prev;
        logic chg;
    } line_t;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_t s_d, s_q;

        always_comb begin
            s_d      = s_q;
            s_d.prev = pins_n[i];
            s_d.chg  = (clr ? 1'b0 : s_q.chg) | (pins_n[i] ^ s_q.prev);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s_q.prev <= 1'b1;
                s_q.chg  <= 1'b0;
            end else begin
                s_q <= s_d;
            end
        end

        assign level[i] = ~pins_n[i];
        assign delta[i] = s_q.chg;

        // R5: a change on a modem input is flagged on the next cycle
        assert_delta_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (pins_n[i] != $past(pins_n[i])) |=> delta[i]);
    end
endmodule

// File: rtl/uart_rb_intr.sv
module uart_rb_intr
    import uart_rb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IER_W-1:0] ier_q,
    input  logic [IER_W-1:0] ier_d,
    input  logic             err_any,
    input  logic             rx_ready,
    input  logic             thre_q,
    input  logic             thre_d,
    input  logic             delta_any,
    input  logic             rd_rbr,
    input  logic             wr_thr,
    input  logic             rd_iir,
    output irq_id_e          irq_id,
    output logic             irq
);
    typedef struct packed {
        logic rda_pend;
        logic thre_pend;
    } pend_t;

    pend_t s_d, s_q;
    logic  rls_act, rda_act, thr_act, ms_act;
    logic  thre_set, thre_clr;

    always_comb begin
        rls_act = ier_q[IE_RLS]  & err_any;
        rda_act = ier_q[IE_RDA]  & s_q.rda_pend;
        thr_act = ier_q[IE_THRE] & s_q.thre_pend;
        ms_act  = ier_q[IE_MS]   & delta_any;

        if (rls_act)      irq_id = ID_RLS;
        else if (rda_act) irq_id = ID_RDA;
        else if (thr_act) irq_id = ID_THRE;
        else              irq_id = ID_MODEM;
        irq = rls_act | rda_act | thr_act | ms_act;

        thre_set = (~thre_q & thre_d) | (~ier_q[IE_THRE] & ier_d[IE_THRE] & thre_q);
        thre_clr = wr_thr | (rd_iir & irq & (irq_id == ID_THRE));

        s_d           = s_q;
        s_d.rda_pend  = rd_rbr ? 1'b0 : (s_q.rda_pend | rx_ready);
        s_d.thre_pend = thre_clr ? 1'b0 : (s_q.thre_pend | thre_set);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9: a receive data read drops the data-ready cause
    assert_rda_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rbr |=> !s_q.rda_pend);
    // R10: a send-byte write drops the holding-empty cause
    assert_thre_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_thr |=> !s_q.thre_pend);
    // R8: no request without some enable bit
    assert_irq_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ier_q != '0));
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
    import uart_rb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       addr,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             irq,
    input  logic [DW-1:0]    rx_data_i,
    input  logic             rx_ready_i,
    input  logic [ERR_W-1:0] rx_err_i,
    input  logic             tx_hold_empty_i,
    input  logic             tx_idle_i,
    input  logic [MDM_W-1:0] modem_n_i,
    output logic             rts_n,
    output logic             dtr_n,
    output logic             rx_pop_o,
    output logic             tx_push_o,
    output logic [DW-1:0]    tx_data_o,
    output logic             rx_fifo_clr_o,
    output logic             tx_fifo_clr_o,
    output logic [DIV_W-1:0] divisor_o,
    output logic [DW-1:0]    line_cfg_o
);
    typedef struct packed {
        logic [IER_W-1:0] ier;
        logic [DW-1:0]    lcr;
        logic [MCR_W-1:0] mcr;
        logic [ERR_W-1:0] err;
        logic             thre;
        logic             temt;
        logic             fifo_en;
        logic             rx_clr;
        logic             tx_clr;
        logic             push;
        logic             pop;
    } ctl_t;

    typedef struct packed {
        logic [DW-1:0] scr;
        logic [DW-1:0] dll;
        logic [DW-1:0] dlm;
        logic [DW-1:0] txd;
    } keep_t;

    ctl_t             s_d, s_q;
    keep_t            k_d, k_q;
    access_t          acc;
    rsel_e            rsel;
    irq_id_e          irq_id;
    logic [MDM_W-1:0] mdm_level, mdm_delta;

    uart_rb_decode i_decode (
        .addr  (addr),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .dlab  (s_q.lcr[DLAB_BIT]),
        .acc   (acc),
        .rsel  (rsel)
    );

    uart_rb_modem #(.LINES(MDM_W)) i_modem (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_n (modem_n_i),
        .clr    (acc.rd_msr),
        .level  (mdm_level),
        .delta  (mdm_delta)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rx_clr = 1'b0;
        s_d.tx_clr = 1'b0;
        s_d.push   = acc.wr_thr;
        s_d.pop    = acc.rd_rbr;
        if (acc.wr_ier) s_d.ier = wdata[IER_W-1:0];
        if (acc.wr_lcr) s_d.lcr = wdata;
        if (acc.wr_mcr) s_d.mcr = wdata[MCR_W-1:0];
        s_d.err  = (acc.rd_lsr ? '0 : s_q.err) | rx_err_i;
        s_d.thre = tx_hold_empty_i;
        s_d.temt = tx_idle_i;
        if (acc.wr_fcr) begin
            s_d.rx_clr  = wdata[1] | (wdata[0] ^ s_q.fifo_en);
            s_d.tx_clr  = wdata[2] | (wdata[0] ^ s_q.fifo_en);
            s_d.fifo_en = wdata[0];
        end

        k_d = k_q;
        if (acc.wr_scr) k_d.scr = wdata;
        if (acc.wr_dll) k_d.dll = wdata;
        if (acc.wr_dlm) k_d.dlm = wdata;
        if (acc.wr_thr) k_d.txd = wdata;
    end

    uart_rb_intr i_intr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ier_q     (s_q.ier),
        .ier_d     (s_d.ier),
        .err_any   (|s_q.err),
        .rx_ready  (rx_ready_i),
        .thre_q    (s_q.thre),
        .thre_d    (s_d.thre),
        .delta_any (|mdm_delta),
        .rd_rbr    (acc.rd_rbr),
        .wr_thr    (acc.wr_thr),
        .rd_iir    (acc.rd_iir),
        .irq_id    (irq_id),
        .irq       (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.thre <= 1'b1;
            s_q.temt <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        k_q <= k_d;
    end

    always_comb begin
        case (rsel)
            RS_RBR:  rdata = rx_data_i;
            RS_IER:  rdata = {{(DW-IER_W){1'b0}}, s_q.ier};
            RS_DLL:  rdata = k_q.dll;
            RS_DLM:  rdata = k_q.dlm;
            RS_IIR:  rdata = {s_q.fifo_en, s_q.fifo_en, 2'b00, irq_id, ~irq};
            RS_LCR:  rdata = s_q.lcr;
            RS_MCR:  rdata = {{(DW-MCR_W){1'b0}}, s_q.mcr};
            RS_LSR:  rdata = {1'b0, s_q.temt, s_q.thre, s_q.err, rx_ready_i};
            RS_MSR:  rdata = {mdm_level, mdm_delta};
            RS_SCR:  rdata = k_q.scr;
            default: rdata = '0;
        endcase
    end

    assign dtr_n         = ~s_q.mcr[0];
    assign rts_n         = ~s_q.mcr[1];
    assign rx_pop_o      = s_q.pop;
    assign tx_push_o     = s_q.push;
    assign tx_data_o     = k_q.txd;
    assign rx_fifo_clr_o = s_q.rx_clr;
    assign tx_fifo_clr_o = s_q.tx_clr;
    assign divisor_o     = {k_q.dlm, k_q.dll};
    assign line_cfg_o    = s_q.lcr;

    // R4: modem control write drives the active-low outputs next cycle
    assert_mcr_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc.wr_mcr |=> (dtr_n == ~$past(wdata[0])) && (rts_n == ~$past(wdata[1])));
    // R11: FIFO control bit 1 yields a receive clear pulse
    assert_rx_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.wr_fcr && wdata[1]) |=> rx_fifo_clr_o);
    // R12: send-byte write pushes the written byte
    assert_push_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acc.wr_thr |=> tx_push_o && (tx_data_o == $past(wdata)));
    // R6: a line status read with no new error empties the error bits
    assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.rd_lsr && rx_err_i == '0) |=> (s_q.err == '0));
endmodule

// File: tb/test_uart_host_regs.sv
module test_uart_host_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]  wdata = 8'h00, rx_data = 8'h00;
    logic        rx_ready = 1'b0;
    logic [3:0]  rx_err = 4'h0;
    logic        tx_hold_empty = 1'b1, tx_idle = 1'b1;
    logic [3:0]  modem_n = 4'hF;
    logic [7:0]  rdata, tx_data_o, line_cfg_o;
    logic        irq, rts_n, dtr_n, rx_pop_o, tx_push_o, rx_fifo_clr_o, tx_fifo_clr_o;
    logic [15:0] divisor_o;

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // behavioural model state
    int m_ier, m_lcr, m_mcr, m_err, m_thre, m_temt, m_fen, m_rda, m_thp, m_delta, m_prev;
    int m_scr = -1, m_dll = -1, m_dlm = -1, m_txd = -1;
    int m_rxclr, m_txclr, m_push, m_pop;

    uart_host_regs i_uart_host_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .irq(irq), .rx_data_i(rx_data),
        .rx_ready_i(rx_ready), .rx_err_i(rx_err), .tx_hold_empty_i(tx_hold_empty),
        .tx_idle_i(tx_idle), .modem_n_i(modem_n), .rts_n(rts_n), .dtr_n(dtr_n),
        .rx_pop_o(rx_pop_o), .tx_push_o(tx_push_o), .tx_data_o(tx_data_o),
        .rx_fifo_clr_o(rx_fifo_clr_o), .tx_fifo_clr_o(tx_fifo_clr_o),
        .divisor_o(divisor_o), .line_cfg_o(line_cfg_o)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int m_iir();
        int v = (m_fen != 0) ? 'hC0 : 0;
        if (m_ier[2] && m_err != 0)        return v | 6;
        if (m_ier[0] && m_rda != 0)        return v | 4;
        if (m_ier[1] && m_thp != 0)        return v | 2;
        if (m_ier[3] && m_delta != 0)      return v | 0;
        return v | 1;
    endfunction

    // returns -1 when the value is not known
    function automatic int m_read(int a);
        bit dl = m_lcr[7];
        case (a)
            0: return dl ? m_dll : int'(rx_data);
            1: return dl ? m_dlm : m_ier;
            2: return m_iir();
            3: return m_lcr;
            4: return m_mcr;
            5: return (m_temt << 6) | (m_thre << 5) | (m_err << 1) | int'(rx_ready);
            6: return ((~int'(modem_n) & 15) << 4) | m_delta;
            default: return m_scr;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin : mdl
        int  iold;
        bit  dl, r_rbr, w_thr, w_ier, r_iir, w_fcr, r_lsr, r_msr, thp_set, thp_clr;
        if (!rst_n) begin
            m_ier = 0; m_lcr = 0; m_mcr = 0; m_err = 0; m_thre = 1; m_temt = 1;
            m_fen = 0; m_rda = 0; m_thp = 0; m_delta = 0; m_prev = 15;
            m_rxclr = 0; m_txclr = 0; m_push = 0; m_pop = 0;
        end else begin
            iold  = m_iir();
            dl    = m_lcr[7];
            r_rbr = rd_en && addr == 0 && !dl;
            w_thr = wr_en && addr == 0 && !dl;
            w_ier = wr_en && addr == 1 && !dl;
            r_iir = rd_en && addr == 2;
            w_fcr = wr_en && addr == 2;
            r_lsr = rd_en && addr == 5;
            r_msr = rd_en && addr == 6;
            thp_set = (m_thre == 0 && tx_hold_empty) ||
                      (w_ier && !m_ier[1] && wdata[1] && m_thre != 0);
            thp_clr = w_thr || (r_iir && (iold & 'hF) == 2);
            m_thp   = thp_clr ? 0 : ((m_thp != 0 || thp_set) ? 1 : 0);
            m_rda   = r_rbr ? 0 : ((m_rda != 0 || rx_ready) ? 1 : 0);
            m_err   = (r_lsr ? 0 : m_err) | int'(rx_err);
            m_delta = (r_msr ? 0 : m_delta) | (int'(modem_n) ^ m_prev);
            m_prev  = int'(modem_n);
            m_thre  = int'(tx_hold_empty);
            m_temt  = int'(tx_idle);
            if (w_ier) m_ier = int'(wdata) & 15;
            if (wr_en && addr == 3) m_lcr = int'(wdata);
            if (wr_en && addr == 4) m_mcr = int'(wdata) & 'h3F;
            if (wr_en && addr == 7) m_scr = int'(wdata);
            if (wr_en && addr == 0 && dl) m_dll = int'(wdata);
            if (wr_en && addr == 1 && dl) m_dlm = int'(wdata);
            if (w_thr) m_txd = int'(wdata);
            m_push = w_thr; m_pop = r_rbr;
            m_rxclr = 0; m_txclr = 0;
            if (w_fcr) begin
                m_rxclr = (wdata[1] || wdata[0] != m_fen[0]) ? 1 : 0;
                m_txclr = (wdata[2] || wdata[0] != m_fen[0]) ? 1 : 0;
                m_fen   = int'(wdata[0]);
            end
        end
    end

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 irq", int'(irq), (m_iir() & 1) == 0 ? 1 : 0);
            chk("R4 rts_n", int'(rts_n), m_mcr[1] ? 0 : 1);
            chk("R4 dtr_n", int'(dtr_n), m_mcr[0] ? 0 : 1);
            chk("R11 rx clear", int'(rx_fifo_clr_o), m_rxclr);
            chk("R11 tx clear", int'(tx_fifo_clr_o), m_txclr);
            chk("R12 push", int'(tx_push_o), m_push);
            chk("R12 pop", int'(rx_pop_o), m_pop);
            chk("R13 line cfg", int'(line_cfg_o), m_lcr);
            if (m_txd >= 0) chk("R12 tx data", int'(tx_data_o), m_txd);
            if (m_dll >= 0 && m_dlm >= 0) chk("R13 divisor", int'(divisor_o), (m_dlm << 8) | m_dll);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk); #1;
        addr = 3'(a); wdata = 8'(d); wr_en = 1'b1; rd_en = 1'b0;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // read; compares with the literal when lit >= 0, else with the model
    task automatic rd(int a, string tag, int lit);
        int exp;
        @(negedge clk); #1;
        addr = 3'(a); rd_en = 1'b1; wr_en = 1'b0;
        #5;
        exp = (lit >= 0) ? lit : m_read(a);
        if (exp >= 0) chk(tag, int'(rdata), exp);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R2 reset view
        rd(1, "R2 ier reset", 'h00);
        rd(2, "R2 iir reset", 'h01);
        rd(3, "R2 lcr reset", 'h00);
        rd(4, "R2 mcr reset", 'h00);
        rd(5, "R2 lsr reset", 'h60);
        rd(6, "R2 msr reset", 'h00);
        chk("R2 rts_n reset", int'(rts_n), 1);
        chk("R2 dtr_n reset", int'(dtr_n), 1);
        // R1 banking
        wr(3, 'h03); rd(3, "R1 lcr readback", 'h03);
        wr(1, 'hFF); rd(1, "R1 ier upper zero", 'h0F);
        rd(2, "R10 enable while empty", 'h02);
        rd(2, "R10 iir read drops cause", 'h01);
        wr(3, 'h83); wr(0, 'h34); wr(1, 'h12);
        rd(0, "R1 divisor low", 'h34); rd(1, "R1 divisor high", 'h12);
        chk("R13 divisor out", int'(divisor_o), 'h1234);
        wr(3, 'h03); rd(1, "R1 ier after bank switch", 'h0F);
        // R3 / R12 scratch and send byte
        wr(7, 'hA5); rd(7, "R3 scratch", 'hA5);
        wr(0, 'h5A);
        step(); chk("R12 tx data", int'(tx_data_o), 'h5A);
        // R4 modem control
        wr(4, 'hFF); rd(4, "R4 mcr upper zero", 'h3F);
        chk("R4 rts low", int'(rts_n), 0); chk("R4 dtr low", int'(dtr_n), 0);
        // master reset mid-run
        step(); rst_n = 1'b0; step(); step(); rst_n = 1'b1;
        rd(4, "R2 mcr after reset", 'h00); rd(1, "R2 ier after reset", 'h00);
        rd(7, "R3 scratch kept", 'hA5);
        chk("R3 tx data kept", int'(tx_data_o), 'h5A);
        wr(3, 'h80); rd(0, "R3 dll kept", 'h34); rd(1, "R3 dlm kept", 'h12);
        wr(3, 'h03);
        // R9 data ready
        wr(1, 'h01);
        step(); rx_data = 8'h77; rx_ready = 1'b1;
        step();
        rd(2, "R7 data ready id", 'h04);
        chk("R8 irq data", int'(irq), 1);
        rd(0, "R1 receive data", 'h77);
        rx_ready = 1'b0;
        step(); chk("R9 cleared by read", int'(irq), 0);
        // R6 / R7 error over data
        wr(1, 'h05);
        step(); rx_ready = 1'b1; rx_err = 4'b0010;
        step(); rx_err = 4'b0000;
        step();
        rd(2, "R7 error outranks data", 'h06);
        rd(5, "R6 lsr with error", 'h65);
        rd(5, "R6 error cleared", 'h61);
        rd(2, "R7 data after error", 'h04);
        rd(0, "R9 pop", -1); rx_ready = 1'b0;
        // R5 modem change
        wr(1, 'h08);
        step(); modem_n[0] = 1'b0;
        step(); step();
        rd(6, "R5 delta set", 'h11);
        rd(6, "R5 delta cleared", 'h10);
        step(); modem_n[0] = 1'b1;
        step(); step();
        chk("R8 modem irq", int'(irq), 1);
        rd(6, "R5 release", 'h01);
        // R10 holding empty
        wr(1, 'h02);
        rd(2, "R10 enable arms", 'h02);
        step(); tx_hold_empty = 1'b0; tx_idle = 1'b0;
        step(); tx_hold_empty = 1'b1;
        step(); step();
        rd(2, "R10 rising edge arms", 'h02);
        rd(5, "R6 idle bit low", 'h20);
        wr(0, 'h99);
        step(); chk("R10 write drops", int'(irq), 0);
        tx_idle = 1'b1;
        // R11 FIFO control
        wr(2, 'h02);
        step(); chk("R11 rx only", int'(rx_fifo_clr_o) * 2 + int'(tx_fifo_clr_o), 2);
        wr(2, 'h04);
        step(); chk("R11 tx only", int'(rx_fifo_clr_o) * 2 + int'(tx_fifo_clr_o), 1);
        wr(2, 'h01);
        step(); chk("R11 enable toggle", int'(rx_fifo_clr_o) * 2 + int'(tx_fifo_clr_o), 3);
        rd(2, "R11 enable in id", 'hC1);
        wr(2, 'h01);
        step(); chk("R11 no toggle", int'(rx_fifo_clr_o) * 2 + int'(tx_fifo_clr_o), 0);
        rd(3, "R11 lcr untouched", 'h03);
        repeat (4) step();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule